// File: doc/BRIEF.md
# Transition-Density Loss-of-Signal Detector

This block watches a serial NRZ bit stream, one bit per clock, and raises a loss-of-signal flag when the stream stops toggling. While the flag is up, the bit handed to downstream logic is held at zero. Downstream logic therefore sees a clean all-zero stream instead of noise when the line fails.

Declaring and clearing use different criteria. The flag is declared after a long run of bits in which no transition occurs. It is cleared only once the most recent window of bits holds more transitions than a threshold. This gives the detector asymmetric hysteresis.

Two control inputs sit beside the data. An active-low enable turns the internal, transition-based detection on or off. An active-low external loss input, normally driven from the optical module's signal-detect output, forces the flag on whenever it is low.

Top module: `trans_los_det`

## Requirements
- R1: The flag is declared when more than DECLARE_RUN (default 128) consecutive sampled bits show no transition. A run of exactly DECLARE_RUN bits without a transition does not declare it.
- R2: An internally declared flag is cleared when the count of transitions among the last WIN_LEN (default 128) sampled bits, the current one included, exceeds CLEAR_THRESH (default 16). A count of exactly CLEAR_THRESH keeps the flag set.
- R3: While los_o is 1, data_o is 0 whatever the serial input is.
- R4: While det_en_n_i is 1, internal detection is off: the internal flag is cleared and stays cleared, so los_o follows only the external input.
- R5: While ext_los_n_i is 0, the next los_o is 1 and the next data_o is 0, whatever the transition history.
- R6: A transition is a sampled bit that differs from the bit sampled one clock earlier. After reset, the previous bit is taken as 0.
- R7: Both outputs are registered with one clock of latency. When no loss is in force, data_o equals the serial bit sampled at the previous clock edge.
- R8: During and right after reset, los_o and data_o are 0, and the run and window counts start from zero.
- R9: The window slides. A transition older than WIN_LEN sampled bits no longer counts toward clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit_i | input | 1 | Serial NRZ data bit |
| det_en_n_i | input | 1 | Active-low enable for transition-based detection |
| ext_los_n_i | input | 1 | Active-low external loss indication |
| los_o | output | 1 | Loss-of-signal flag |
| data_o | output | 1 | Serial bit passed downstream, forced to 0 during loss |

## Verification
The bench builds two copies of the block with the default thresholds: 128-bit run, 128-bit window and a clear threshold of 16. One copy keeps its history in the ring-buffer variant and the other in the shift-register variant, so both generate branches are checked against the same reference model. The default sizes make the exact boundaries reachable in a short run: a 128-bit versus a 129-bit dead run, 16 versus 17 transitions, and transitions that age out of the window just before new ones arrive. Random stretches of dense, sparse and dead data, with external-loss pulses and enable toggles mixed in, exercise the hysteresis from many states.

// File: rtl/los_det_pkg.sv
package los_det_pkg;

   // History storage variants for the sliding transition window
   localparam int HIST_SHIFT = 0;
   localparam int HIST_RING  = 1;

   typedef enum logic {
      LOS_IDLE   = 1'b0,
      LOS_ACTIVE = 1'b1
   } los_state_e;

endpackage

// File: rtl/los_run_tracker.sv
module los_run_tracker #(
   parameter int RUN_LIMIT = 128,
   localparam int RUN_MAX  = RUN_LIMIT + 1,
   localparam int RUN_W    = $clog2(RUN_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_i,
   output logic trans_o,
   output logic run_over_o
);

   logic             prev_q;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_d;

   assign trans_o = bit_i ^ prev_q;

   always_comb begin
      if (trans_o)
         run_d = '0;
      else if (run_q == RUN_W'(RUN_MAX))
         run_d = run_q;
      else
         run_d = run_q + RUN_W'(1);
   end

   assign run_over_o = (run_d > RUN_W'(RUN_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         run_q  <= '0;
      end else begin
         prev_q <= bit_i;
         run_q  <= run_d;
      end
   end

endmodule

// File: rtl/los_window_counter.sv
module los_window_counter
   import los_det_pkg::*;
#(
   parameter int WIN_LEN    = 128,
   parameter int HIST_STYLE = HIST_SHIFT,
   localparam int CNT_W     = $clog2(WIN_LEN + 1),
   localparam int PTR_W     = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trans_i,
   output logic [CNT_W-1:0] count_next_o
);

   logic [CNT_W-1:0] count_q;
   logic             oldest;

   generate
      if (HIST_STYLE == HIST_RING) begin : g_ring
         logic [WIN_LEN-1:0] slot_q;
         logic [PTR_W-1:0]   ptr_q;

         assign oldest = slot_q[ptr_q];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
               ptr_q  <= '0;
            end else begin
               slot_q[ptr_q] <= trans_i;
               if (ptr_q == PTR_W'(WIN_LEN - 1))
                  ptr_q <= '0;
               else
                  ptr_q <= ptr_q + PTR_W'(1);
            end
         end
      end else begin : g_shift
         logic [WIN_LEN-1:0] hist_q;

         assign oldest = hist_q[WIN_LEN-1];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hist_q <= '0;
            else
               hist_q <= {hist_q[WIN_LEN-2:0], trans_i};
         end
      end
   endgenerate

   assign count_next_o = count_q + CNT_W'(trans_i) - CNT_W'(oldest);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else
         count_q <= count_next_o;
   end

endmodule

// File: rtl/trans_los_det.sv
module trans_los_det
   import los_det_pkg::*;
#(
   parameter int DECLARE_RUN  = 128,
   parameter int WIN_LEN      = 128,
   parameter int CLEAR_THRESH = 16,
   parameter int HIST_STYLE   = HIST_SHIFT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_bit_i,
   input  logic det_en_n_i,
   input  logic ext_los_n_i,
   output logic los_o,
   output logic data_o
);

   localparam int CNT_W = $clog2(WIN_LEN + 1);

   // Elaboration-time parameter checks
   if (DECLARE_RUN < 1) begin : g_bad_run
      $error("DECLARE_RUN must be at least 1");
   end
   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end
   if (CLEAR_THRESH < 0 || CLEAR_THRESH >= WIN_LEN) begin : g_bad_thr
      $error("CLEAR_THRESH must lie in 0 .. WIN_LEN-1");
   end
   if (HIST_STYLE != HIST_SHIFT && HIST_STYLE != HIST_RING) begin : g_bad_style
      $error("HIST_STYLE selects an unknown history variant");
   end

   logic             trans;
   logic             run_over;
   logic [CNT_W-1:0] win_count;
   los_state_e       state_q;
   los_state_e       state_d;
   logic             los_d;

   los_run_tracker #(
      .RUN_LIMIT (DECLARE_RUN)
   ) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_i      (ser_bit_i),
      .trans_o    (trans),
      .run_over_o (run_over)
   );

   los_window_counter #(
      .WIN_LEN    (WIN_LEN),
      .HIST_STYLE (HIST_STYLE)
   ) u_win (
      .clk          (clk),
      .rst_n        (rst_n),
      .trans_i      (trans),
      .count_next_o (win_count)
   );

   always_comb begin
      state_d = state_q;
      if (det_en_n_i)
         state_d = LOS_IDLE;
      else if (state_q == LOS_IDLE && run_over)
         state_d = LOS_ACTIVE;
      else if (state_q == LOS_ACTIVE && win_count > CNT_W'(CLEAR_THRESH))
         state_d = LOS_IDLE;
   end

   assign los_d = (state_d == LOS_ACTIVE) | ~ext_los_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LOS_IDLE;
         los_o   <= 1'b0;
         data_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         los_o   <= los_d;
         data_o  <= ser_bit_i & ~los_d;
      end
   end

endmodule

// File: rtl/los_det_chk.sv
module los_det_chk #(
   parameter int DECLARE_RUN = 128,
   localparam int CK_MAX     = DECLARE_RUN + 1,
   localparam int CK_W       = $clog2(CK_MAX + 1)
) (
   input logic clk,
   input logic rst_n,
   input logic ser_bit_i,
   input logic det_en_n_i,
   input logic ext_los_n_i,
   input logic los_o,
   input logic data_o
);

   logic            ck_prev;
   logic [CK_W-1:0] ck_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_prev <= 1'b0;
         ck_run  <= '0;
      end else begin
         ck_prev <= ser_bit_i;
         if (ser_bit_i != ck_prev)
            ck_run <= '0;
         else if (ck_run != CK_W'(CK_MAX))
            ck_run <= ck_run + CK_W'(1);
      end
   end

   // R5
   ext_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_los_n_i |=> (los_o && !data_o));

   // R4
   disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en_n_i && ext_los_n_i) |=> !los_o);

   // R7
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en_n_i && ext_los_n_i) |=> (data_o == $past(ser_bit_i)));

   // R1
   declare_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(los_o) && $past(ext_los_n_i)) |-> (ck_run > CK_W'(DECLARE_RUN)));

   // R3
   zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      los_o |-> !data_o);

endmodule

bind trans_los_det los_det_chk #(
   .DECLARE_RUN (DECLARE_RUN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ser_bit_i   (ser_bit_i),
   .det_en_n_i  (det_en_n_i),
   .ext_los_n_i (ext_los_n_i),
   .los_o       (los_o),
   .data_o      (data_o)
);

// File: tb/trans_los_det_tb.sv
module trans_los_det_tb;

   localparam int RUN = 128;
   localparam int WIN = 128;
   localparam int THR = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser = 1'b0;
   logic en_n = 1'b0;
   logic ext_n = 1'b1;
   logic los_a, dat_a, los_b, dat_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model state
   logic m_prev;
   logic m_hist [WIN];
   int   m_run;
   logic m_los;
   logic exp_los, exp_dat;

   always #2.5 clk = ~clk;

   trans_los_det #(.DECLARE_RUN(RUN), .WIN_LEN(WIN), .CLEAR_THRESH(THR),
                   .HIST_STYLE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_bit_i(ser), .det_en_n_i(en_n),
      .ext_los_n_i(ext_n), .los_o(los_a), .data_o(dat_a));

   trans_los_det #(.DECLARE_RUN(RUN), .WIN_LEN(WIN), .CLEAR_THRESH(THR),
                   .HIST_STYLE(0)) u_dut_shift (
      .clk(clk), .rst_n(rst_n), .ser_bit_i(ser), .det_en_n_i(en_n),
      .ext_los_n_i(ext_n), .los_o(los_b), .data_o(dat_b));

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int win_count();
      int n = 0;
      for (int i = 0; i < WIN; i++) n += int'(m_hist[i]);
      return n;
   endfunction

   task automatic model_reset();
      m_prev = 1'b0; m_run = 0; m_los = 1'b0;
      for (int i = 0; i < WIN; i++) m_hist[i] = 1'b0;
      exp_los = 1'b0; exp_dat = 1'b0;
   endtask

   task automatic model_step(input logic b, input logic e_n, input logic x_n);
      logic t;
      t = (b != m_prev);
      m_prev = b;
      for (int i = WIN - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = t;
      m_run = t ? 0 : ((m_run < 100000) ? m_run + 1 : m_run);
      if (e_n) m_los = 1'b0;
      else if (!m_los && m_run > RUN) m_los = 1'b1;
      else if (m_los && win_count() > THR) m_los = 1'b0;
      exp_los = m_los | ~x_n;
      exp_dat = exp_los ? 1'b0 : b;
   endtask

   // Drive one bit, let the edge take it, compare both variants at negedge
   task automatic step(input logic b, input logic e_n, input logic x_n);
      string tag;
      ser = b; en_n = e_n; ext_n = x_n;
      @(posedge clk);
      model_step(b, e_n, x_n);
      @(negedge clk);
      tag = !x_n ? "R5" : (e_n ? "R4" : (exp_los ? "R3" : "R7"));
      chk(tag, los_a, exp_los, "ring los_o");
      chk(tag, dat_a, exp_dat, "ring data_o");
      chk(tag, los_b, exp_los, "shift los_o");
      chk(tag, dat_b, exp_dat, "shift data_o");
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ser = 1'b0; en_n = 1'b0; ext_n = 1'b1;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8", los_a, 1'b0, "los_o in reset");
      chk("R8", dat_a, 1'b0, "data_o in reset");
      chk("R8", los_b, 1'b0, "shift los_o in reset");
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic b;
      int mode, len;
      void'($urandom(32'd20240611));
      do_reset();

      // R8: counts start empty, first 0 bit is no transition (R6)
      step(1'b0, 1'b0, 1'b1);
      chk("R8", los_a, 1'b0, "los_o after first bit");
      chk("R6", dat_a, 1'b0, "data_o passes first 0");

      // R1: exactly RUN dead bits do not declare, one more does
      for (int i = 1; i < RUN; i++) step(1'b0, 1'b0, 1'b1);
      chk("R1", los_a, 1'b0, "no declare after 128 dead bits");
      step(1'b0, 1'b0, 1'b1);
      chk("R1", los_a, 1'b1, "declare after 129 dead bits");

      // R3 + R2: 16 transitions keep the flag, the 17th clears it
      b = 1'b0;
      for (int i = 0; i < THR; i++) begin
         b = ~b;
         step(b, 1'b0, 1'b1);
         if (i == 0) chk("R3", dat_a, 1'b0, "data forced low on a 1 bit");
      end
      chk("R2", los_a, 1'b1, "16 transitions keep loss");
      step(b, 1'b0, 1'b1);
      chk("R2", los_a, 1'b1, "still held after steady bit");
      b = ~b;
      step(b, 1'b0, 1'b1);
      chk("R2", los_a, 1'b0, "17th transition clears loss");
      chk("R7", dat_a, b, "data follows input after clear");

      // R9: transitions aged out of the window no longer count
      for (int i = 0; i < RUN + 2; i++) step(b, 1'b0, 1'b1);
      chk("R1", los_a, 1'b1, "declared again");
      for (int i = 0; i < 10; i++) begin b = ~b; step(b, 1'b0, 1'b1); end
      for (int i = 0; i < WIN; i++) step(b, 1'b0, 1'b1);
      for (int i = 0; i < 10; i++) begin b = ~b; step(b, 1'b0, 1'b1); end
      chk("R9", los_a, 1'b1, "old transitions dropped from window");

      // R4: disabling detection clears and holds it clear over a dead line
      step(b, 1'b1, 1'b1);
      chk("R4", los_a, 1'b0, "disable clears loss");
      for (int i = 0; i < RUN + 20; i++) step(b, 1'b1, 1'b1);
      chk("R4", los_a, 1'b0, "no declare while disabled");
      chk("R7", dat_a, b, "data passes while disabled");

      // R5: external loss forces the flag even with detection off
      step(1'b1, 1'b1, 1'b0);
      chk("R5", los_a, 1'b1, "external loss forces flag");
      chk("R5", dat_a, 1'b0, "external loss zeroes data");
      step(1'b1, 1'b1, 1'b1);
      chk("R5", los_a, 1'b0, "flag drops with external loss released");

      // Constrained random stretches
      b = 1'b0;
      for (int blk = 0; blk < 60; blk++) begin
         mode = int'($urandom % 4);
         len = 200 + int'($urandom % 400);
         for (int i = 0; i < len; i++) begin
            case (mode)
               0: b = logic'($urandom % 2);
               1: if ($urandom % 12 == 0) b = ~b;
               2: ;
               default: if ($urandom % 20 == 0) b = ~b;
            endcase
            if (mode == 3)
               step(b, logic'($urandom % 50 == 0), logic'($urandom % 40 != 0));
            else
               step(b, 1'b0, 1'b1);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule